// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block is a two-wire serial bus slave that presents a 256-byte presence-detect memory to an external bus master. SCL and SDA arrive as plain inputs sampled by the system clock. SDA is driven back as an open-drain enable: a 1 pulls the wire low, and a 0 releases it. The block finds START and STOP conditions and compares the device address. It then runs write transactions and three kinds of read: from the current counter, from a chosen location, and sequential bursts. All of these share one internal byte counter.

The memory is filled at reset from a parameter image. The checksum byte of that image is computed at elaboration, so any image handed in arrives already sealed. The lower half of the memory is write-protected. There is no valid/ready edge: the master's SCL is the only pacing. The slave never holds SCL low, so the master may stall between bits or bytes for as long as it likes. Every response is produced within a few system clocks after an SCL edge is seen.

Top module: `spd_eeprom_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a new address phase from any state, including a repeated START in mid-transaction. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R2: Before the first START, and after an address that does not match, the slave drives nothing and takes no action on any byte until the next START.
- R3: The address byte is sent MSB first. Its upper seven bits must equal 1010000, and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges only on a full match, so 0xA0 and 0xA1 are acknowledged and 0xA2 is not.
- R4: For every byte it receives and accepts (address, word address, data), the slave holds SDA low through the ninth SCL clock.
- R5: Read data goes out MSB first. After each byte the slave releases SDA and samples the master's ninth bit. Low means it sends the next byte. High means it stays released and ignores traffic until a START.
- R6: In a write transaction, the first byte after the address loads the counter. A repeated START with a read address then returns the byte at that location.
- R7: The counter steps by one after every byte read or written and wraps from 255 to 0. A read that starts without a word address begins at the counter.
- R8: Data bytes written to addresses 128 to 255 are stored and can be read back.
- R9: Data bytes written to addresses 0 to 127 are acknowledged and advance the counter, but the stored byte does not change.
- R10: The default image holds (37·k + 11) mod 256 at byte k. The exception is byte 63, which holds the low 8 bits of the sum of bytes 0 to 62.
- R11: After reset SDA is released. The drive enable changes only right after a detected SCL falling edge, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with its default parameters:
- the full 256-byte image,
- a protection limit of 128,
- the 1010000 device address,
- two synchroniser stages.

With these values, the wrap from 255 to 0 and a write that crosses into the protected area can both be reached with short bursts. The checksum byte and its neighbours are read through the ordinary random-read path. Bus quarter-periods of eight system clocks leave room for the synchroniser delay before each change the slave makes on SDA.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_DEPTH = 256;
  localparam int SPD_AW    = $clog2(SPD_DEPTH);

  typedef logic [SPD_DEPTH-1:0][7:0] spd_image_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_DEV, ST_ACK_DEV, ST_RX_WADDR, ST_ACK_WADDR,
    ST_RX_DATA, ST_ACK_DATA, ST_TX, ST_RACK
  } spd_state_e;

  // computed fill pattern used when no image is supplied
  function automatic spd_image_t default_image();
    spd_image_t img;
    for (int k = 0; k < SPD_DEPTH; k++) img[k] = 8'((k * 37 + 11) % 256);
    return img;
  endfunction

  // replace byte at pos with the 8-bit sum of every byte below it
  function automatic spd_image_t seal_image(spd_image_t raw, int pos);
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < pos; k++) s = s + raw[k];
    raw[pos] = s;
    return raw;
  endfunction
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int                 PROT_LIMIT = 128,
  parameter int                 CSUM_POS   = 63,
  parameter spd_pkg::spd_image_t INIT_IMAGE = spd_pkg::default_image()
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [spd_pkg::SPD_AW-1:0] wr_addr,
  input  logic [7:0]                 wr_data,
  output spd_pkg::spd_image_t        img_q
);
  localparam spd_pkg::spd_image_t SEALED = spd_pkg::seal_image(INIT_IMAGE, CSUM_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) img_q <= SEALED;
    else if (wr_en && (int'(wr_addr) >= PROT_LIMIT)) img_q[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/spd_bus_fsm.sv
module spd_bus_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       sda_lvl,
  input  logic                       start_evt,
  input  logic                       stop_evt,
  input  logic [7:0]                 rd_data,
  output spd_pkg::spd_state_e        state_o,
  output logic [spd_pkg::SPD_AW-1:0] ctr_o,
  output logic                       sda_oe,
  output logic                       wr_en,
  output logic [spd_pkg::SPD_AW-1:0] wr_addr,
  output logic [7:0]                 wr_data
);
  import spd_pkg::*;

  spd_state_e st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rw, mack;

  assign state_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0; mack <= 1'b0;
      ctr_o <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_evt) begin
        st <= ST_RX_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX_DEV, ST_RX_WADDR, ST_RX_DATA: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_RX_DEV) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1; rw <= sh[0]; st <= ST_ACK_DEV;
                end else st <= ST_IDLE;
              end else if (st == ST_RX_WADDR) begin
                sda_oe <= 1'b1; ctr_o <= sh; st <= ST_ACK_WADDR;
              end else begin
                sda_oe <= 1'b1; wr_en <= 1'b1; wr_addr <= ctr_o; wr_data <= sh;
                ctr_o <= ctr_o + 1'b1; st <= ST_ACK_DATA;
              end
            end
          end
          ST_ACK_DEV, ST_RACK: begin
            if (st == ST_RACK && scl_rise) mack <= ~sda_lvl;
            if (scl_fall) begin
              if ((st == ST_ACK_DEV && rw) || (st == ST_RACK && mack)) begin
                tx     <= {rd_data[6:0], 1'b0};
                sda_oe <= ~rd_data[7];
                ctr_o  <= ctr_o + 1'b1;
                cnt    <= 4'd1;
                st     <= ST_TX;
              end else if (st == ST_ACK_DEV) begin
                sda_oe <= 1'b0; st <= ST_RX_WADDR;
              end else st <= ST_IDLE;
            end
          end
          ST_ACK_WADDR, ST_ACK_DATA: begin
            if (scl_fall) begin
              sda_oe <= 1'b0; st <= ST_RX_DATA;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; mack <= 1'b0; st <= ST_RACK;
              end else begin
                sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter logic [6:0]          DEV_ADDR    = 7'b1010000,
  parameter int                  PROT_LIMIT  = 128,
  parameter int                  CSUM_POS    = 63,
  parameter int                  SYNC_STAGES = 2,
  parameter spd_pkg::spd_image_t INIT_IMAGE  = spd_pkg::default_image()
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import spd_pkg::*;
  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;

  logic [1:0] lvl, rise, fall;
  logic       start_evt, stop_evt, scl_fall;
  logic       wr_en;
  logic [SPD_AW-1:0] wr_addr, ctr;
  logic [7:0] wr_data;
  spd_image_t img_q;
  spd_state_e state;

  spd_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall));

  assign scl_fall  = fall[LN_SCL];
  assign start_evt = fall[LN_SDA] & lvl[LN_SCL] & ~rise[LN_SCL];
  assign stop_evt  = rise[LN_SDA] & lvl[LN_SCL] & ~rise[LN_SCL];

  spd_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(rise[LN_SCL]), .scl_fall(scl_fall),
    .sda_lvl(lvl[LN_SDA]), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(img_q[ctr]), .state_o(state), .ctr_o(ctr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  spd_store #(.PROT_LIMIT(PROT_LIMIT), .CSUM_POS(CSUM_POS), .INIT_IMAGE(INIT_IMAGE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .img_q(img_q));
endmodule

// File: rtl/spd_eeprom_slave_chk.sv
module spd_eeprom_slave_chk #(
  parameter int PROT_LIMIT = 128
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sda_oe,
  input logic                       scl_fall,
  input logic                       start_evt,
  input logic                       stop_evt,
  input spd_pkg::spd_state_e        state,
  input logic [spd_pkg::SPD_AW-1:0] ctr,
  input spd_pkg::spd_image_t        img_q
);
  import spd_pkg::*;

  p_start_addr_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_RX_DEV && !sda_oe));

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctr) && $past(state) != ST_RX_WADDR) |-> (ctr == $past(ctr) + 1'b1));

  p_lowprot_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(img_q[PROT_LIMIT-1:0]));

  p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));
endmodule

bind spd_eeprom_slave spd_eeprom_slave_chk #(.PROT_LIMIT(PROT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .state(state), .ctr(ctr),
  .img_q(img_q));

// File: tb/spd_eeprom_slave_tb_top.sv
module spd_eeprom_slave_tb_top;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  assign sda_line = ~(m_low | sda_oe);
  always #(CLK_NS/2) clk = ~clk;

  spd_eeprom_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; waitq(Q); m_scl = 1'b1; waitq(Q);
    m_low = 1'b1; waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q); m_low = 1'b0; waitq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~v[i]; waitq(Q); m_scl = 1'b1; waitq(2*Q); m_scl = 1'b0; waitq(Q);
    end
    m_low = 1'b0; waitq(Q); m_scl = 1'b1; waitq(Q);
    ack = ~sda_line; waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic rd_byte(input bit give_ack);
    logic [7:0] v;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; waitq(Q); v[i] = sda_line; waitq(Q); m_scl = 1'b0; waitq(Q);
      if (i != 0) waitq(Q);
    end
    m_low = give_ack; waitq(Q); m_scl = 1'b1; waitq(2*Q); m_scl = 1'b0; waitq(Q);
    m_low = 1'b0;
    got_q.push_back(v);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic addr_write(input logic [7:0] a, input string tag);
    bit ack;
    bus_start();
    wr_byte(8'hA0, ack); chk(ack, {tag, " R3 dev ack"}, ack, 1);
    wr_byte(a, ack);     chk(ack, {tag, " R4 word ack"}, ack, 1);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    bit ack;
    addr_write(a, tag);
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, {tag, " R6 read ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      expect_byte(model[8'(a + i)], tag);
      rd_byte(i != n - 1);
    end
    bus_stop();
  endtask

  task automatic write_seq(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input int n, input string tag);
    bit ack;
    logic [7:0] dv;
    addr_write(a, tag);
    for (int i = 0; i < n; i++) begin
      dv = (i == 0) ? d0 : d1;
      wr_byte(dv, ack); chk(ack, {tag, " R4 data ack"}, ack, 1);
      if (int'(8'(a + i)) >= 128) model[8'(a + i)] = dv;
    end
    bus_stop();
  endtask

  // monitor: compare each observed read byte against the scoreboard
  initial begin
    logic [7:0] g, e;
    string t;
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected read byte", g, 0);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(g == e, t, g, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] s;
    for (int k = 0; k < 256; k++) model[k] = 8'((k * 37 + 11) % 256);
    s = 8'h00;
    for (int k = 0; k < 63; k++) s = s + model[k];
    model[63] = s;

    waitq(5); rst_n = 1'b1; waitq(5);
    chk(sda_oe == 1'b0, "R11 reset release", sda_oe, 0);

    // R2: traffic before any START is ignored
    m_scl = 1'b0; waitq(Q);
    wr_byte(8'hA0, ack); chk(!ack, "R2 no start no ack", ack, 0);
    bus_stop();

    // R10 / R6 / R5: random read with sequential continuation
    rand_read(8'h00, 4, "R10 R6 R5 bytes 0..3");
    rand_read(8'd62, 2, "R10 checksum 62..63");

    // R7: current-address read continues at 64
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, "R7 current read ack", ack, 1);
    expect_byte(model[64], "R7 current address");
    rd_byte(1'b0);
    bus_stop();

    // R3 / R2: mismatched select bits, following bytes unacknowledged
    bus_start();
    wr_byte(8'hA2, ack); chk(!ack, "R3 wrong address nack", ack, 0);
    wr_byte(8'h55, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, "R2 counter untouched ack", ack, 1);
    expect_byte(model[65], "R2 R7 counter untouched");
    rd_byte(1'b0);
    bus_stop();

    // R8: writes above the protected area
    write_seq(8'd200, 8'h3C, 8'h5D, 2, "R8 write 200");
    rand_read(8'd200, 2, "R8 readback 200");
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, "R7 after read ack", ack, 1);
    expect_byte(model[202], "R7 post-increment 202");
    rd_byte(1'b0);
    bus_stop();

    // R9: protected write is acknowledged but not stored
    write_seq(8'd10, 8'hFF, 8'hFF, 1, "R9 protected write");
    rand_read(8'd10, 1, "R9 protected readback");

    // R7 wrap and protection crossing 255 -> 0
    write_seq(8'd254, 8'h11, 8'h22, 2, "R7 wrap write");
    write_seq(8'd255, 8'h22, 8'h77, 2, "R9 wrap into protected");
    rand_read(8'd254, 4, "R7 wrap read 254..1");

    // R5: after NACK the slave stays silent until START
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, "R5 read ack", ack, 1);
    expect_byte(model[2], "R5 byte before nack");
    rd_byte(1'b0);
    wr_byte(8'hFF, ack); chk(!ack, "R5 silent after nack", ack, 0);
    chk(sda_oe == 1'b0, "R5 released after nack", sda_oe, 0);
    bus_stop();

    // R1: repeated start mid-write restarts address phase
    bus_start();
    wr_byte(8'hA0, ack); chk(ack, "R1 first address ack", ack, 1);
    bus_start();
    wr_byte(8'hA1, ack); chk(ack, "R1 repeated start ack", ack, 1);
    expect_byte(model[3], "R1 read after restart");
    rd_byte(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R1 stop releases", sda_oe, 0);

    waitq(4);
    chk(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule